// File: doc/BRIEF.md
# Multi-channel bus receive DMA

This block takes words from the read side of a bus receive FIFO and moves them into a shared dual-port memory. The bus interleaves address words, which are flagged by an address-valid bit, with data words. Each address word picks the packet channel that gets the data words after it. Every channel has its own memory window, word budget and listen address.

Software programs a channel through shadow registers, then starts it by writing its bit into the initialize register. A channel that has stored its full budget stops listening and raises its status bit. An address word that no listening channel claims is not consumed: it blocks the FIFO, its value is latched for software, and a flag is raised. Software then either starts a channel that claims the address, or reads the status register, which throws the address word and the data behind it away.

One active-high interrupt output combines all pending status bits, gated by an enable bit.

Top module: `bus_rx_dma`

## Requirements
- R1: After reset, the status register reads 0, `irq_o` is low, and neither `rx_re_o` nor `mem_we_o` is asserted.
- R2: Each channel n has three shadow registers: memory base at register address {n,4'h8}, word budget at {n,4'h9} and listen address at {n,4'hA}. Writing them has no effect on reception until the channel is next initialized. The base and listen registers read back the written shadow value.
- R3: Writing the initialize register (address 0x00) with bit n set loads channel n's shadow values into its working state and clears its received count. Any number of bits may be set in one write. A channel loaded with a budget of 0 stays idle.
- R4: An address word is claimed by a listening channel when bits [CMP_HI:CMP_LO] of the word equal the same bits of that channel's listen address. When several channels match, the lowest-numbered one wins.
- R5: Each data word goes to the memory at the current channel's base plus its received count, with every byte enable set. The count and the FIFO read advance only in a cycle where `mem_we_o` is high and `mem_wait_i` is low.
- R6: Reading a channel's budget register {n,4'h9} returns the number of words that channel has stored since its last initialization.
- R7: When a channel stores the last word of its budget, it stops listening and sets status bit n (status register at address 0x02). Writing 1 to status bit n clears it, and writing 0 leaves it unchanged.
- R8: An address word that no listening channel claims is held in the FIFO with `rx_re_o` low. Status bit ADDR_W-1 is set, and register 0x07 returns the held address.
- R9: Reading the status register clears bit ADDR_W-1. If an unclaimed address word is still at the FIFO head at that moment, that word is popped and discarded.
- R10: If a channel that claims the held address is initialized while the FIFO is stalled, reception resumes and the data goes to that channel.
- R11: `irq_o` is high exactly when bit 1 of the control register (address 0x01) is set and at least one status bit is set.
- R12: Data words that arrive while no active channel is selected are popped and discarded. This includes the data following a discarded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cs_i | input | 1 | Register port select |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe |
| cfg_addr_i | input | ch_bits(N_CHAN)+4 | Register address, channel index in upper bits |
| cfg_wdata_i | input | ADDR_W | Register write data |
| cfg_rdata_o | output | ADDR_W | Register read data, combinational |
| rx_data_i | input | DATA_W | FIFO head word |
| rx_av_i | input | 1 | Head word is an address |
| rx_empty_i | input | 1 | FIFO empty |
| rx_comm_i | input | 5 | Bus command of head word (not decoded) |
| rx_re_o | output | 1 | Pop FIFO head |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_we_o | output | 1 | Memory write request |
| mem_be_o | output | DATA_W/8 | Byte enables |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_wait_i | input | 1 | Memory stall |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The bench sends interleaved address and data words to two channels. Matches are made only on the upper address slice, and the memory stall toggles while words flow. A design that advanced its count on a stalled write, or popped during a stall, would show skipped or repeated memory addresses on the scoreboard. Both channels listen on the same address to check that the lower channel wins, and an address is held before the channel that should own it is initialized; a design that latched shadow values early would accept that word at once. Discarding an unclaimed address is followed by data that must not reach the channel selected before it, so a design that keeps the old selection would write memory that the scoreboard does not expect.

// File: rtl/bus_rx_dma_pkg.sv
package bus_rx_dma_pkg;
  localparam logic [3:0] OFS_INIT = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h1;
  localparam logic [3:0] OFS_STAT = 4'h2;
  localparam logic [3:0] OFS_HELD = 4'h7;
  localparam logic [3:0] OFS_BASE = 4'h8;
  localparam logic [3:0] OFS_BUDG = 4'h9;
  localparam logic [3:0] OFS_LSN  = 4'hA;

  localparam int CTRL_IE_BIT = 1;

  function automatic int ch_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bus_rx_dma_chan.sv
module bus_rx_dma_chan #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int WORDS_W = 8,
  parameter int CMP_LO  = 0,
  parameter int CMP_HI  = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  wdata_i,
  input  logic               we_base_i,
  input  logic               we_budg_i,
  input  logic               we_lsn_i,
  input  logic               init_i,
  input  logic [DATA_W-1:0]  probe_i,
  input  logic               adv_i,
  output logic               hit_o,
  output logic               active_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [WORDS_W-1:0] cnt_o,
  output logic [ADDR_W-1:0]  base_sh_o,
  output logic [ADDR_W-1:0]  lsn_sh_o,
  output logic               done_o
);
  logic [ADDR_W-1:0]  base_sh_q, lsn_sh_q, base_q, lsn_q;
  logic [WORDS_W-1:0] budg_sh_q, tgt_q, cnt_q, cnt_nxt;
  logic               active_q;

  assign cnt_nxt = cnt_q + 1'b1;
  assign done_o  = adv_i && active_q && (cnt_nxt == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_sh_q <= '0;
      lsn_sh_q  <= '0;
      budg_sh_q <= '0;
    end else begin
      if (we_base_i) base_sh_q <= wdata_i;
      if (we_lsn_i)  lsn_sh_q  <= wdata_i;
      if (we_budg_i) budg_sh_q <= wdata_i[WORDS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      lsn_q    <= '0;
      tgt_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (init_i) begin
      base_q   <= base_sh_q;
      lsn_q    <= lsn_sh_q;
      tgt_q    <= budg_sh_q;
      cnt_q    <= '0;
      active_q <= (budg_sh_q != '0);
    end else if (adv_i && active_q) begin
      cnt_q <= cnt_nxt;
      if (done_o) active_q <= 1'b0;
    end
  end

  assign hit_o     = active_q && (probe_i[CMP_HI:CMP_LO] == lsn_q[CMP_HI:CMP_LO]);
  assign active_o  = active_q;
  assign addr_o    = base_q + ADDR_W'(cnt_q);
  assign cnt_o     = cnt_q;
  assign base_sh_o = base_sh_q;
  assign lsn_sh_o  = lsn_sh_q;

  // R7: a listening channel is always short of its budget
  p_cnt_below_budget_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < tgt_q));

  p_done_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !init_i) |=> !active_q);

  p_count_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !init_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bus_rx_dma_route.sv
module bus_rx_dma_route
  import bus_rx_dma_pkg::*;
#(
  parameter int N_CHAN = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rx_av_i,
  input  logic                        rx_empty_i,
  input  logic [N_CHAN-1:0]           hit_i,
  input  logic [N_CHAN-1:0]           active_i,
  input  logic                        mem_wait_i,
  input  logic                        held_i,
  input  logic                        clr_held_i,
  output logic                        rx_re_o,
  output logic                        mem_we_o,
  output logic [ch_bits(N_CHAN)-1:0]  sel_o,
  output logic [N_CHAN-1:0]           adv_o,
  output logic                        set_held_o
);
  localparam int CH_W = ch_bits(N_CHAN);

  logic [CH_W-1:0] cur_q, hit_idx;
  logic            cur_v_q, drop_q;
  logic            any_hit, addr_head, data_head, stall, tgt_ok;

  always_comb begin
    hit_idx = '0;
    for (int i = N_CHAN - 1; i >= 0; i--) begin
      if (hit_i[i]) hit_idx = CH_W'(i);
    end
  end

  assign any_hit   = |hit_i;
  assign addr_head = !rx_empty_i && rx_av_i;
  assign data_head = !rx_empty_i && !rx_av_i;
  assign stall     = addr_head && !any_hit;
  assign tgt_ok    = cur_v_q && active_i[cur_q];

  assign mem_we_o   = data_head && tgt_ok;
  assign rx_re_o    = (addr_head && any_hit) || (stall && drop_q) ||
                      (data_head && (!tgt_ok || !mem_wait_i));
  assign set_held_o = stall && !held_i && !drop_q;
  assign sel_o      = cur_q;

  always_comb begin
    adv_o = '0;
    if (mem_we_o && !mem_wait_i) adv_o[cur_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      cur_v_q <= 1'b0;
      drop_q  <= 1'b0;
    end else if (rx_re_o && addr_head) begin
      cur_v_q <= any_hit;
      if (any_hit) cur_q <= hit_idx;
      drop_q  <= 1'b0;
    end else if (clr_held_i && stall) begin
      drop_q <= 1'b1;
    end
  end

  p_pop_needs_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_re_o |-> !rx_empty_i);

  p_no_pop_on_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_wait_i) |-> !rx_re_o);

  // R8: the flag rises while the unclaimed word is still held
  p_hold_after_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_i) |-> !rx_re_o);

  p_one_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adv_o));
endmodule

// File: rtl/bus_rx_dma_regs.sv
module bus_rx_dma_regs
  import bus_rx_dma_pkg::*;
#(
  parameter int N_CHAN  = 2,
  parameter int ADDR_W  = 16,
  parameter int WORDS_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_cs_i,
  input  logic                             cfg_we_i,
  input  logic                             cfg_re_i,
  input  logic [ch_bits(N_CHAN)+3:0]       cfg_addr_i,
  input  logic [ADDR_W-1:0]                cfg_wdata_i,
  output logic [ADDR_W-1:0]                cfg_rdata_o,
  input  logic [N_CHAN-1:0][WORDS_W-1:0]   cnt_i,
  input  logic [N_CHAN-1:0][ADDR_W-1:0]    base_sh_i,
  input  logic [N_CHAN-1:0][ADDR_W-1:0]    lsn_sh_i,
  input  logic [N_CHAN-1:0]                done_i,
  input  logic                             set_held_i,
  input  logic [ADDR_W-1:0]                head_i,
  output logic [N_CHAN-1:0]                init_o,
  output logic [N_CHAN-1:0]                we_base_o,
  output logic [N_CHAN-1:0]                we_budg_o,
  output logic [N_CHAN-1:0]                we_lsn_o,
  output logic                             held_o,
  output logic                             clr_held_o,
  output logic                             irq_o
);
  localparam int CH_W = ch_bits(N_CHAN);

  logic [3:0]        ofs;
  logic [CH_W-1:0]   chn;
  logic              glob, wr, rd, wr_stat;
  logic              ie_q, held_q;
  logic [N_CHAN-1:0] irq_q;
  logic [ADDR_W-1:0] cap_q;

  assign ofs     = cfg_addr_i[3:0];
  assign chn     = cfg_addr_i[CH_W+3:4];
  assign glob    = (chn == '0) && !ofs[3];
  assign wr      = cfg_cs_i && cfg_we_i;
  assign rd      = cfg_cs_i && cfg_re_i;
  assign wr_stat = wr && glob && (ofs == OFS_STAT);

  assign init_o     = (wr && glob && ofs == OFS_INIT) ? cfg_wdata_i[N_CHAN-1:0] : '0;
  assign clr_held_o = rd && glob && (ofs == OFS_STAT) && held_q;

  for (genvar n = 0; n < N_CHAN; n++) begin : g_dec
    logic sel;
    assign sel          = wr && (chn == CH_W'(n)) && ofs[3];
    assign we_base_o[n] = sel && (ofs == OFS_BASE);
    assign we_budg_o[n] = sel && (ofs == OFS_BUDG);
    assign we_lsn_o[n]  = sel && (ofs == OFS_LSN);

    p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && cfg_wdata_i[n] && !done_i[n]) |=> !irq_q[n]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      irq_q  <= '0;
      held_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      if (wr && glob && ofs == OFS_CTRL) ie_q <= cfg_wdata_i[CTRL_IE_BIT];
      irq_q <= done_i | (irq_q & ~(wr_stat ? cfg_wdata_i[N_CHAN-1:0] : '0));
      if (set_held_i) begin
        held_q <= 1'b1;
        cap_q  <= head_i;
      end else if (clr_held_o) begin
        held_q <= 1'b0;
      end
    end
  end

  assign held_o = held_q;
  assign irq_o  = ie_q && ((|irq_q) || held_q);

  always_comb begin
    cfg_rdata_o = '0;
    if (glob) begin
      case (ofs)
        OFS_CTRL: cfg_rdata_o[CTRL_IE_BIT] = ie_q;
        OFS_STAT: begin
          cfg_rdata_o[N_CHAN-1:0] = irq_q;
          cfg_rdata_o[ADDR_W-1]   = held_q;
        end
        OFS_HELD: cfg_rdata_o = cap_q;
        default:  cfg_rdata_o = '0;
      endcase
    end else begin
      for (int n = 0; n < N_CHAN; n++) begin
        if (chn == CH_W'(n) && ofs[3]) begin
          case (ofs)
            OFS_BASE: cfg_rdata_o = base_sh_i[n];
            OFS_BUDG: cfg_rdata_o = ADDR_W'(cnt_i[n]);
            OFS_LSN:  cfg_rdata_o = lsn_sh_i[n];
            default:  cfg_rdata_o = '0;
          endcase
        end
      end
    end
  end

  p_read_clears_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_held_o |=> !held_q);

  p_ie_off_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && glob && ofs == OFS_CTRL && !cfg_wdata_i[CTRL_IE_BIT]) |=> !irq_o);

  p_flag_pends_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q && held_q) |-> irq_o);
endmodule

// File: rtl/bus_rx_dma.sv
module bus_rx_dma
  import bus_rx_dma_pkg::*;
#(
  parameter int N_CHAN  = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int WORDS_W = 8,
  parameter int CMP_LO  = 0,
  parameter int CMP_HI  = ADDR_W - 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_cs_i,
  input  logic                        cfg_we_i,
  input  logic                        cfg_re_i,
  input  logic [ch_bits(N_CHAN)+3:0]  cfg_addr_i,
  input  logic [ADDR_W-1:0]           cfg_wdata_i,
  output logic [ADDR_W-1:0]           cfg_rdata_o,
  input  logic [DATA_W-1:0]           rx_data_i,
  input  logic                        rx_av_i,
  input  logic                        rx_empty_i,
  input  logic [4:0]                  rx_comm_i,
  output logic                        rx_re_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic                        mem_we_o,
  output logic [DATA_W/8-1:0]         mem_be_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic                        mem_wait_i,
  output logic                        irq_o
);
  localparam int CH_W = ch_bits(N_CHAN);

  logic [N_CHAN-1:0]              hit, active, adv, done, init;
  logic [N_CHAN-1:0]              we_base, we_budg, we_lsn;
  logic [N_CHAN-1:0][ADDR_W-1:0]  waddr, base_sh, lsn_sh;
  logic [N_CHAN-1:0][WORDS_W-1:0] cnt;
  logic [CH_W-1:0]                sel;
  logic                           held, clr_held, set_held;
  logic [4:0]                     comm_unused;

  assign comm_unused = rx_comm_i;

  for (genvar n = 0; n < N_CHAN; n++) begin : g_chan
    bus_rx_dma_chan #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_W(WORDS_W),
      .CMP_LO(CMP_LO), .CMP_HI(CMP_HI)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wdata_i   (cfg_wdata_i),
      .we_base_i (we_base[n]),
      .we_budg_i (we_budg[n]),
      .we_lsn_i  (we_lsn[n]),
      .init_i    (init[n]),
      .probe_i   (rx_data_i),
      .adv_i     (adv[n]),
      .hit_o     (hit[n]),
      .active_o  (active[n]),
      .addr_o    (waddr[n]),
      .cnt_o     (cnt[n]),
      .base_sh_o (base_sh[n]),
      .lsn_sh_o  (lsn_sh[n]),
      .done_o    (done[n])
    );
  end

  bus_rx_dma_route #(.N_CHAN(N_CHAN)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_av_i    (rx_av_i),
    .rx_empty_i (rx_empty_i),
    .hit_i      (hit),
    .active_i   (active),
    .mem_wait_i (mem_wait_i),
    .held_i     (held),
    .clr_held_i (clr_held),
    .rx_re_o    (rx_re_o),
    .mem_we_o   (mem_we_o),
    .sel_o      (sel),
    .adv_o      (adv),
    .set_held_o (set_held)
  );

  bus_rx_dma_regs #(.N_CHAN(N_CHAN), .ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_cs_i    (cfg_cs_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_re_i    (cfg_re_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .cnt_i       (cnt),
    .base_sh_i   (base_sh),
    .lsn_sh_i    (lsn_sh),
    .done_i      (done),
    .set_held_i  (set_held),
    .head_i      (rx_data_i[ADDR_W-1:0]),
    .init_o      (init),
    .we_base_o   (we_base),
    .we_budg_o   (we_budg),
    .we_lsn_o    (we_lsn),
    .held_o      (held),
    .clr_held_o  (clr_held),
    .irq_o       (irq_o)
  );

  assign mem_addr_o  = waddr[sel];
  assign mem_wdata_o = rx_data_i;
  assign mem_be_o    = '1;

  // R5: a stalled write holds its address and data
  p_write_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_wait_i && init == '0) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/bus_rx_dma_bench.sv
module bus_rx_dma_bench;
  localparam int CLK_P = 10;
  localparam int NCH = 2, DW = 32, AW = 16, WW = 8;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          cfg_cs = 0, cfg_we = 0, cfg_re = 0;
  logic [4:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0, cfg_rdata;
  logic [DW-1:0] rx_data = '0;
  logic          rx_av = 0, rx_empty = 1, rx_re;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_wait = 0, irq;
  logic [DW/8-1:0] mem_be;
  logic [DW-1:0] mem_wdata;

  bus_rx_dma #(.N_CHAN(NCH), .DATA_W(DW), .ADDR_W(AW), .WORDS_W(WW),
               .CMP_LO(4), .CMP_HI(15)) u_bus_rx_dma (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_cs_i(cfg_cs), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .rx_data_i(rx_data), .rx_av_i(rx_av), .rx_empty_i(rx_empty), .rx_comm_i(5'h2),
    .rx_re_o(rx_re), .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_wait_i(mem_wait), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed { logic av; logic [DW-1:0] d; } fword_t;
  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } mword_t;

  fword_t fq[$];
  mword_t exq[$];
  int checks = 0, fails = 0, cyc = 0, wait_mode = 0;
  logic fire = 0, acc = 0, be_ok = 0;
  logic [AW-1:0] acc_a;
  logic [DW-1:0] acc_d;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // FIFO model and memory stall pattern
  always @(negedge clk) begin
    if (fire) void'(fq.pop_front());
    rx_empty <= (fq.size() == 0);
    rx_av    <= (fq.size() != 0) ? fq[0].av : 1'b0;
    rx_data  <= (fq.size() != 0) ? fq[0].d : '0;
    mem_wait <= (wait_mode == 2) || (wait_mode == 1 && cyc[0]);
  end

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    fire  <= rx_re;
    acc   <= mem_we && !mem_wait;
    acc_a <= mem_addr;
    acc_d <= mem_wdata;
    be_ok <= &mem_be;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (acc) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R12 unexpected write", {16'h0, acc_a}, 32'h0);
      end else begin
        mword_t e;
        e = exq.pop_front();
        chk(acc_a == e.a, "R5 write address", {16'h0, acc_a}, {16'h0, e.a});
        chk(acc_d == e.d, "R4 write data", acc_d, e.d);
        chk(be_ok, "R5 byte enables", {31'h0, be_ok}, 32'h1);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000) begin
      chk(1'b0, "watchdog", cyc, 50000);
      finish_run();
    end
  end

  task automatic cfg_wr(input logic [4:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_cs = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_cs = 0; cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [4:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    cfg_cs = 1; cfg_re = 1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_cs = 0; cfg_re = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [AW-1:0] exp, input string tag);
    logic [AW-1:0] v;
    cfg_rd(a, v);
    chk(v == exp, tag, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic push_a(input logic [AW-1:0] a);
    fq.push_back('{av: 1'b1, d: {16'h0, a}});
  endtask

  task automatic push_d(input logic [DW-1:0] d, input logic [AW-1:0] at, input bit expect_it);
    fq.push_back('{av: 1'b0, d: d});
    if (expect_it) exq.push_back('{a: at, d: d});
  endtask

  task automatic idle();
    while (fq.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic pin_chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk); #2;
    chk(ok, tag, act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk); #2;
    chk(!irq, "R1 irq low", irq, 0);
    chk(!rx_re && !mem_we, "R1 no traffic", {rx_re, mem_we}, 0);
    rd_chk(5'h02, 16'h0000, "R1 status zero");

    // R2 shadow setup, not yet effective
    cfg_wr(5'h08, 16'h0100); cfg_wr(5'h09, 16'd3); cfg_wr(5'h0A, 16'h1230);
    cfg_wr(5'h18, 16'h0200); cfg_wr(5'h19, 16'd2); cfg_wr(5'h1A, 16'h4560);
    rd_chk(5'h0A, 16'h1230, "R2 listen readback");
    rd_chk(5'h18, 16'h0200, "R2 base readback");
    push_a(16'h1230);
    repeat (4) @(negedge clk); #2;
    chk(!rx_re, "R8 held address not popped", rx_re, 0);
    chk(fq.size() == 1, "R2 shadow not live before init", fq.size(), 1);
    rd_chk(5'h07, 16'h1230, "R8 captured address");
    chk(!irq, "R11 irq gated off", irq, 0);
    cfg_wr(5'h01, 16'h0002);
    @(negedge clk); #2;
    chk(irq, "R11 irq with enable", irq, 1);

    // R10 init releases the stall
    for (int i = 0; i < 3; i++) push_d(32'hA000_0000 + i, 16'h0100 + 16'(i), 1);
    cfg_wr(5'h00, 16'h0001);
    idle();
    rd_chk(5'h09, 16'd3, "R6 received count ch0");
    rd_chk(5'h02, 16'h8001, "R7 R8 status bits");
    rd_chk(5'h02, 16'h0001, "R9 flag cleared by read");
    chk(irq, "R11 irq from channel bit", irq, 1);
    cfg_wr(5'h02, 16'h0000);
    rd_chk(5'h02, 16'h0001, "R7 write zero keeps bit");
    cfg_wr(5'h02, 16'h0001);
    rd_chk(5'h02, 16'h0000, "R7 write one clears");
    @(negedge clk); #2;
    chk(!irq, "R11 irq idle", irq, 0);

    // R3 R4 R5 both channels, slice match, toggling stall
    cfg_wr(5'h08, 16'h0300);
    wait_mode = 1;
    cfg_wr(5'h00, 16'h0003);
    push_a(16'h1234); push_d(32'hB000_0000, 16'h0300, 1);
    push_a(16'h4569); push_d(32'hC000_0000, 16'h0200, 1); push_d(32'hC000_0001, 16'h0201, 1);
    push_a(16'h123F); push_d(32'hB000_0001, 16'h0301, 1); push_d(32'hB000_0002, 16'h0302, 1);
    idle();
    wait_mode = 0;
    rd_chk(5'h02, 16'h0003, "R3 both channels completed");
    rd_chk(5'h19, 16'd2, "R6 received count ch1");
    cfg_wr(5'h02, 16'h0003);

    // R4 lowest channel wins on equal listen addresses
    cfg_wr(5'h09, 16'd1); cfg_wr(5'h19, 16'd1); cfg_wr(5'h1A, 16'h1230);
    cfg_wr(5'h00, 16'h0003);
    push_a(16'h1230); push_d(32'hD000_0000, 16'h0300, 1);
    idle();
    rd_chk(5'h02, 16'h0001, "R4 priority to channel 0");
    push_a(16'h1230); push_d(32'hD000_0001, 16'h0200, 1);
    idle();
    rd_chk(5'h02, 16'h0003, "R4 second goes to channel 1");
    cfg_wr(5'h02, 16'h0003);

    // R5 held write under constant stall
    cfg_wr(5'h19, 16'd2); cfg_wr(5'h1A, 16'h4560);
    cfg_wr(5'h00, 16'h0002);
    wait_mode = 2;
    push_a(16'h4560); push_d(32'hE000_0000, 16'h0200, 1);
    repeat (6) @(negedge clk); #2;
    chk(mem_we && !rx_re, "R5 request held, no pop", {mem_we, rx_re}, 2'b10);
    chk(mem_addr == 16'h0200, "R5 held address", {16'h0, mem_addr}, 32'h200);
    rd_chk(5'h19, 16'd0, "R6 count frozen during stall");
    wait_mode = 0;
    idle();
    rd_chk(5'h19, 16'd1, "R6 count after release");

    // R9 R12 discard unclaimed address and its data
    push_a(16'h7770); push_d(32'hF000_0000, 16'h0, 0); push_d(32'hF000_0001, 16'h0, 0);
    repeat (4) @(negedge clk); #2;
    chk(fq.size() == 3, "R8 stall holds fifo", fq.size(), 3);
    rd_chk(5'h07, 16'h7770, "R8 capture second address");
    rd_chk(5'h02, 16'h8000, "R8 flag in status");
    idle();
    rd_chk(5'h02, 16'h0000, "R9 flag gone after read");
    rd_chk(5'h19, 16'd1, "R12 dropped data not stored");

    // R12 fresh unknown after a drop flags again
    push_a(16'h8880);
    repeat (4) @(negedge clk);
    rd_chk(5'h07, 16'h8880, "R8 new capture after drop");
    rd_chk(5'h02, 16'h8000, "R9 read clears and drops");
    idle();
    pin_chk(rx_empty, "R9 fifo drained", rx_empty, 1);
    chk(exq.size() == 0, "R5 all expected writes seen", exq.size(), 0);
    finish_run();
  end
endmodule